// File: doc/BRIEF.md
# Configuration Port Unlock Controller

This block provides a locked configuration space reached through two byte-wide I/O ports: an index port and a data port. After reset the space is closed. The host opens it by writing a fixed four-byte key to the index port. Once the space is open, the host writes a register number to the index port and then reads or writes that register through the data port.

A device-select register chooses which bank of per-device registers the data port can reach. Every bank holds an enable bit and a 16-bit base address. Bank 7 also holds four watchdog control bytes. Three global read-only registers report a 16-bit identifier and a revision number. A specific write through the data port closes the space again. The bus is modelled as an address, a write strobe, a read strobe and byte data. Read data is registered.

Top module: `cfg_port_ctrl`

## Requirements
- R1: After reset the space is locked, the device-select register (index 0x07) is 0, and the enable bit (index 0x30) of every bank is 0.
- R2: The space unlocks when 0x87, 0x01, 0x55 and 0x55 are written in that order to the index port (I/O address 0x2E). An incomplete key leaves it locked. The unlock takes effect for the port access that follows the final key write.
- R3: A key byte that does not match the expected byte restarts matching from the beginning. If that mismatching byte is 0x87, it counts as the first key byte.
- R4: While the space is locked, writes to the data port (I/O address 0x2F) have no effect, and reads of the data port return 0xFF.
- R5: A read strobe on a port updates io_rdata on the clock after the strobe. io_rdata then holds that value until the next port read.
- R6: Writing 0x02 to the data port while the index is 0x02 relocks the space. Writing any other value at index 0x02 has no effect.
- R7: Index 0x07 selects the bank and reads back its value. A write of a value at or above NUM_DEV (16) is ignored.
- R8: Indices 0x20 and 0x21 return the identifier high byte (0x87) and low byte (0x16). Index 0x22 returns the revision (3) in bits 3:0 and 0 in bits 7:4. Writes to these indices are ignored.
- R9: Index 0x30 is a per-bank enable held in bit 0. Bits 7:1 read as 0. Each bank keeps its own bit.
- R10: Indices 0x60 and 0x61 are the high and low bytes of a per-bank 16-bit base address. Each bank keeps its own value.
- R11: Indices 0x71 to 0x74 are four writable watchdog bytes that exist only in bank 7. In any other bank those indices read as 0x00 and ignore writes.
- R12: Indices with no register read as 0x00. A read of the index port returns the current index when unlocked and 0xFF when locked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O address of the current strobe |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe, one cycle per byte |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |

## Verification
Every write takes effect at the clock edge that samples its strobe. The result can therefore be observed by the next access, including the change between locked and unlocked. Read data is due one edge after the read strobe. The bench drives each strobe for one cycle between falling edges, releases it at the next falling edge, and samples io_rdata at that point, after the registering edge. One check waits several further cycles and confirms that io_rdata still holds the value.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam logic [7:0] IDX_LOCK    = 8'h02;
  localparam logic [7:0] LOCK_CODE   = 8'h02;
  localparam logic [7:0] IDX_DEVSEL  = 8'h07;
  localparam logic [7:0] IDX_ID_HI   = 8'h20;
  localparam logic [7:0] IDX_ID_LO   = 8'h21;
  localparam logic [7:0] IDX_REV     = 8'h22;
  localparam logic [7:0] IDX_ENABLE  = 8'h30;
  localparam logic [7:0] IDX_BASE_HI = 8'h60;
  localparam logic [7:0] IDX_BASE_LO = 8'h61;
  localparam logic [7:0] IDX_WDT0    = 8'h71;
  localparam logic [7:0] LOCKED_READ = 8'hFF;
endpackage

// File: rtl/cfg_key_match.sv
module cfg_key_match #(
  parameter int          KEY_LEN = 4,
  parameter logic [31:0] KEY_SEQ = 32'h8701_5555
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  input  logic       relock,
  output logic       unlocked
);
  localparam int STEP_W = (KEY_LEN > 2) ? $clog2(KEY_LEN) : 1;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(KEY_LEN - 1);
  localparam logic [7:0] FIRST_BYTE = KEY_SEQ[8*(KEY_LEN-1) +: 8];

  logic [STEP_W-1:0] step_q;
  logic              open_q;
  logic [7:0]        want;

  always_comb want = KEY_SEQ[8*(KEY_LEN-1-int'(step_q)) +: 8];

  always_ff @(posedge clk) begin
    if (rst || relock) begin
      step_q <= '0;
      open_q <= 1'b0;
    end else if (key_wr && !open_q) begin
      if (key_byte == want) begin
        if (step_q == LAST_STEP) begin
          open_q <= 1'b1;
          step_q <= '0;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end else if (key_byte == FIRST_BYTE) begin
        step_q <= STEP_W'(1);
      end else begin
        step_q <= '0;
      end
    end
  end

  assign unlocked = open_q;
endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
  import cfg_port_pkg::*;
#(
  parameter int NUM_DEV = 16,
  parameter int LDN_W   = $clog2(NUM_DEV)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LDN_W-1:0] ldn,
  input  logic             wr_en,
  input  logic [7:0]       idx,
  input  logic [7:0]       wdata,
  output logic             enable_rd,
  output logic [15:0]      base_rd
);
  logic [NUM_DEV-1:0] enable_q;
  logic [7:0]         base_hi_mem [NUM_DEV];
  logic [7:0]         base_lo_mem [NUM_DEV];

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_enable
    always_ff @(posedge clk) begin
      if (rst)
        enable_q[g] <= 1'b0;
      else if (wr_en && idx == IDX_ENABLE && ldn == LDN_W'(g))
        enable_q[g] <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && idx == IDX_BASE_HI) base_hi_mem[ldn] <= wdata;
    if (wr_en && idx == IDX_BASE_LO) base_lo_mem[ldn] <= wdata;
  end

  assign enable_rd = enable_q[ldn];
  assign base_rd   = {base_hi_mem[ldn], base_lo_mem[ldn]};
endmodule

// File: rtl/cfg_wdt_regs.sv
module cfg_wdt_regs
  import cfg_port_pkg::*;
#(
  parameter int WDT_REGS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] idx,
  input  logic [7:0] wdata,
  output logic       hit,
  output logic [7:0] rd_data
);
  localparam int OFF_W = (WDT_REGS > 2) ? $clog2(WDT_REGS) : 1;

  logic [7:0] regs_q [WDT_REGS];
  logic [7:0] off;

  always_comb begin
    off     = idx - IDX_WDT0;
    hit     = (idx >= IDX_WDT0) && (int'(off) < WDT_REGS);
    rd_data = hit ? regs_q[off[OFF_W-1:0]] : 8'h00;
  end

  for (genvar g = 0; g < WDT_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs_q[g] <= 8'h00;
      else if (wr_en && hit && off == 8'(g))
        regs_q[g] <= wdata;
    end
  end
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfg_port_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] INDEX_PORT = 16'h002E,
  parameter logic [15:0] DATA_PORT  = 16'h002F,
  parameter int          NUM_DEV    = 16,
  parameter logic [15:0] CHIP_ID    = 16'h8716,
  parameter logic [3:0]  CHIP_REV   = 4'h3,
  parameter int          WDT_LDN    = 7,
  parameter int          WDT_REGS   = 4,
  parameter int          KEY_LEN    = 4,
  parameter logic [31:0] KEY_SEQ    = 32'h8701_5555
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata
);
  localparam int LDN_W = $clog2(NUM_DEV);
  localparam logic [LDN_W-1:0] WDT_BANK = LDN_W'(WDT_LDN);

  logic             unlocked;
  logic [7:0]       index_q;
  logic [LDN_W-1:0] ldn_q;
  logic             idx_sel, dat_sel, key_wr, cfg_wr, relock;
  logic             enable_rd, wdt_hit;
  logic [15:0]      base_rd;
  logic [7:0]       wdt_rd, cfg_value, rdata_q;

  assign idx_sel = (io_addr == ADDR_W'(INDEX_PORT));
  assign dat_sel = (io_addr == ADDR_W'(DATA_PORT));
  assign key_wr  = io_wr && idx_sel && !unlocked;
  assign cfg_wr  = io_wr && dat_sel && unlocked;
  assign relock  = cfg_wr && index_q == IDX_LOCK && io_wdata == LOCK_CODE;

  cfg_key_match #(.KEY_LEN(KEY_LEN), .KEY_SEQ(KEY_SEQ)) u_key (
    .clk(clk), .rst(rst), .key_wr(key_wr), .key_byte(io_wdata),
    .relock(relock), .unlocked(unlocked)
  );

  always_ff @(posedge clk) begin
    if (rst || relock)
      index_q <= 8'h00;
    else if (io_wr && idx_sel && unlocked)
      index_q <= io_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)
      ldn_q <= '0;
    else if (cfg_wr && index_q == IDX_DEVSEL && int'(io_wdata) < NUM_DEV)
      ldn_q <= io_wdata[LDN_W-1:0];
  end

  cfg_dev_bank #(.NUM_DEV(NUM_DEV), .LDN_W(LDN_W)) u_bank (
    .clk(clk), .rst(rst), .ldn(ldn_q), .wr_en(cfg_wr), .idx(index_q),
    .wdata(io_wdata), .enable_rd(enable_rd), .base_rd(base_rd)
  );

  cfg_wdt_regs #(.WDT_REGS(WDT_REGS)) u_wdt (
    .clk(clk), .rst(rst), .wr_en(cfg_wr && ldn_q == WDT_BANK),
    .idx(index_q), .wdata(io_wdata), .hit(wdt_hit), .rd_data(wdt_rd)
  );

  always_comb begin
    unique case (index_q)
      IDX_DEVSEL:  cfg_value = 8'(ldn_q);
      IDX_ID_HI:   cfg_value = CHIP_ID[15:8];
      IDX_ID_LO:   cfg_value = CHIP_ID[7:0];
      IDX_REV:     cfg_value = {4'h0, CHIP_REV};
      IDX_ENABLE:  cfg_value = {7'h00, enable_rd};
      IDX_BASE_HI: cfg_value = base_rd[15:8];
      IDX_BASE_LO: cfg_value = base_rd[7:0];
      default:     cfg_value = (wdt_hit && ldn_q == WDT_BANK) ? wdt_rd : 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= LOCKED_READ;
    else if (io_rd && dat_sel)
      rdata_q <= unlocked ? cfg_value : LOCKED_READ;
    else if (io_rd && idx_sel)
      rdata_q <= unlocked ? index_q : LOCKED_READ;
  end

  assign io_rdata = rdata_q;
endmodule

// File: rtl/cfg_port_ctrl_chk.sv
module cfg_port_ctrl_chk #(
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] INDEX_PORT = 16'h002E,
  parameter logic [15:0] DATA_PORT  = 16'h002F,
  parameter logic [15:0] CHIP_ID    = 16'h8716,
  parameter logic [7:0]  KEY_LAST   = 8'h55,
  parameter int          LDN_W      = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              unlocked,
  input logic [7:0]        index_q,
  input logic [LDN_W-1:0]  ldn_q
);
  // R4
  locked_read_ff_chk: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_addr == ADDR_W'(DATA_PORT) && !unlocked) |=> io_rdata == 8'hFF);

  // R4
  locked_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == ADDR_W'(DATA_PORT) && !unlocked) |=> ($stable(ldn_q) && $stable(index_q)));

  // R2
  unlock_by_key_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(io_wr && io_addr == ADDR_W'(INDEX_PORT) && io_wdata == KEY_LAST));

  // R6
  relock_chk: assert property (@(posedge clk) disable iff (rst)
    (unlocked && io_wr && io_addr == ADDR_W'(DATA_PORT) && index_q == 8'h02 && io_wdata == 8'h02)
      |=> !unlocked);

  // R8
  chip_id_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (unlocked && io_rd && io_addr == ADDR_W'(DATA_PORT) && index_q == 8'h20)
      |=> io_rdata == CHIP_ID[15:8]);
endmodule

bind cfg_port_ctrl cfg_port_ctrl_chk #(
  .ADDR_W(ADDR_W), .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT),
  .CHIP_ID(CHIP_ID), .KEY_LAST(KEY_SEQ[7:0]), .LDN_W(LDN_W)
) u_chk (
  .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .unlocked(unlocked),
  .index_q(index_q), .ldn_q(ldn_q)
);

// File: tb/cfg_port_ctrl_test.sv
module cfg_port_ctrl_test;
  localparam logic [15:0] IP = 16'h002E;
  localparam logic [15:0] DP = 16'h002F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  cfg_port_ctrl uut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
    wr(IP, idx);
    wr(DP, d);
  endtask

  task automatic reg_rd(input logic [7:0] idx, output logic [7:0] d);
    wr(IP, idx);
    rd(DP, d);
  endtask

  task automatic unlock();
    wr(IP, 8'h87); wr(IP, 8'h01); wr(IP, 8'h55); wr(IP, 8'h55);
  endtask

  task automatic relock();
    reg_wr(8'h02, 8'h02);
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    check("R1 rdata at reset", io_rdata, 8'hFF);
    rd(DP, d); check("R1 locked after reset", d, 8'hFF);
    rd(IP, d); check("R12 index port locked", d, 8'hFF);
    unlock();
    reg_rd(8'h07, d); check("R1 device select zero", d, 8'h00);
    reg_rd(8'h30, d); check("R1 enable bank0 zero", d, 8'h00);
    reg_wr(8'h07, 8'h09);
    reg_rd(8'h30, d); check("R1 enable bank9 zero", d, 8'h00);
    reg_wr(8'h07, 8'h00);
    relock();
  endtask

  task automatic t_locked_ignore();
    logic [7:0] d;
    wr(IP, 8'h07);
    wr(DP, 8'h05);
    rd(DP, d); check("R4 locked data read", d, 8'hFF);
    unlock();
    reg_rd(8'h07, d); check("R4 locked write ignored", d, 8'h00);
    relock();
  endtask

  task automatic t_unlock();
    logic [7:0] d;
    wr(IP, 8'h87); wr(IP, 8'h01); wr(IP, 8'h55);
    rd(DP, d); check("R2 partial key stays locked", d, 8'hFF);
    wr(IP, 8'h55);
    reg_rd(8'h20, d); check("R2 unlocked id read", d, 8'h87);
    relock();
  endtask

  task automatic t_wrong_byte();
    logic [7:0] d;
    wr(IP, 8'h87); wr(IP, 8'h01); wr(IP, 8'h33); wr(IP, 8'h55); wr(IP, 8'h55);
    rd(DP, d); check("R3 wrong byte restarts", d, 8'hFF);
    wr(IP, 8'h87); wr(IP, 8'h87); wr(IP, 8'h01); wr(IP, 8'h55); wr(IP, 8'h55);
    reg_rd(8'h21, d); check("R3 repeated first byte", d, 8'h16);
    relock();
    wr(IP, 8'h87); wr(IP, 8'h01); wr(IP, 8'h55); wr(IP, 8'h87);
    wr(IP, 8'h01); wr(IP, 8'h55); wr(IP, 8'h55);
    reg_rd(8'h21, d); check("R3 late first byte restarts at step one", d, 8'h16);
    relock();
  endtask

  task automatic t_relock();
    logic [7:0] d;
    unlock();
    reg_wr(8'h02, 8'h05);
    reg_rd(8'h20, d); check("R6 other code keeps unlocked", d, 8'h87);
    relock();
    rd(DP, d); check("R6 relocked", d, 8'hFF);
  endtask

  task automatic t_devsel();
    logic [7:0] d;
    unlock();
    reg_wr(8'h07, 8'h03);
    reg_rd(8'h07, d); check("R7 device select readback", d, 8'h03);
    reg_wr(8'h07, 8'h10);
    reg_rd(8'h07, d); check("R7 out of range ignored", d, 8'h03);
  endtask

  task automatic t_id_ro();
    logic [7:0] d;
    reg_wr(8'h20, 8'h00);
    reg_rd(8'h20, d); check("R8 id high read-only", d, 8'h87);
    reg_rd(8'h21, d); check("R8 id low", d, 8'h16);
    reg_rd(8'h22, d); check("R8 revision", d, 8'h03);
  endtask

  task automatic t_enable();
    logic [7:0] d;
    reg_wr(8'h07, 8'h02); reg_wr(8'h30, 8'hFF);
    reg_rd(8'h30, d); check("R9 enable bit only", d, 8'h01);
    reg_wr(8'h07, 8'h05);
    reg_rd(8'h30, d); check("R9 other bank clear", d, 8'h00);
    reg_wr(8'h07, 8'h02);
    reg_rd(8'h30, d); check("R9 bank keeps bit", d, 8'h01);
  endtask

  task automatic t_base();
    logic [7:0] d;
    reg_wr(8'h07, 8'h02); reg_wr(8'h60, 8'h12); reg_wr(8'h61, 8'h34);
    reg_wr(8'h07, 8'h05); reg_wr(8'h60, 8'hAB); reg_wr(8'h61, 8'hCD);
    reg_rd(8'h60, d); check("R10 bank5 base high", d, 8'hAB);
    reg_wr(8'h07, 8'h02);
    reg_rd(8'h60, d); check("R10 bank2 base high", d, 8'h12);
    reg_rd(8'h61, d); check("R10 R5 bank2 base low", d, 8'h34);
    repeat (3) @(negedge clk);
    check("R5 rdata held", io_rdata, 8'h34);
  endtask

  task automatic t_wdt();
    logic [7:0] d;
    reg_wr(8'h07, 8'h07);
    for (int i = 0; i < 4; i++) reg_wr(8'(8'h71 + i), 8'(8'hA1 + i));
    for (int i = 0; i < 4; i++) begin
      reg_rd(8'(8'h71 + i), d); check("R11 watchdog byte", d, 8'(8'hA1 + i));
    end
    reg_wr(8'h07, 8'h03);
    reg_rd(8'h72, d); check("R11 absent outside bank7", d, 8'h00);
    reg_wr(8'h73, 8'h55);
    reg_wr(8'h07, 8'h07);
    reg_rd(8'h73, d); check("R11 write outside bank7 ignored", d, 8'hA3);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    reg_rd(8'h50, d); check("R12 unmapped reads zero", d, 8'h00);
    rd(IP, d); check("R12 index port readback", d, 8'h50);
    relock();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_locked_ignore();
    t_unlock();
    t_wrong_byte();
    t_relock();
    t_devsel();
    t_id_ro();
    t_enable();
    t_base();
    t_wdt();
    t_unmapped();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog all actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule